// File: doc/BRIEF.md
# Reset-Run Wake Timeout Controller

This block decides whether an LED driver in shutdown should start on its own when its external bus-enable pin is released. The pin is active low. While it is low the serial bus interface is held off, and any transaction in progress is dropped as though a STOP had been seen. When software has armed the feature in the configuration register, a rising edge on the pin opens a timeout window. The window is measured in ticks of the slow PWM clock. If the device acknowledges no bus transaction before the window closes, the block sets the run bit. That takes the driver out of shutdown and starts any programmed ramp-up.

If the device acknowledges its own slave address during the window, the wake is cancelled. The arming bit is cleared, the run bit stays low and the driver remains in shutdown. A low pulse on the pin that comes before expiry throws the attempt away, and the next rising edge starts a fresh window. A separate configuration bit can be set so that driving the pin low also returns the whole configuration register to its power-on value.

The block runs on the system clock. It receives the PWM tick as a one-cycle strobe. The pin passes through a two-flop synchronizer. An acknowledge is held pending until the next tick.

Top module: `reset_run_wake`

## Requirements
- R1: After reset, cfg_o equals the power-on value (0x00 by default), window_active_o, wake_o and regs_clear_o are 0, and bus_abort_o is 1 while ext_en_i is low.
- R2: When cfg bit 1 (arm) is set, a rising edge on ext_en_i opens a window. On the 128th tick strobe after the window opens, with no acknowledge seen, cfg bit 0 (run) is set and wake_o pulses for one cycle. After 127 ticks the run bit is still 0.
- R3: A rising edge on ext_en_i while cfg bit 1 is clear opens no window and never sets the run bit.
- R4: If ext_en_i goes low while a window is open, the window closes with no change to cfg. The next qualifying rising edge restarts the full 128-tick count.
- R5: An acknowledge (ack_i) during an open window cancels the wake at the next tick strobe. cfg bit 1 is cleared, cfg bit 0 stays 0, and later ticks do not set the run bit.
- R6: An acknowledge that comes in the same cycle as the 128th tick strobe cancels the wake instead of letting it expire.
- R7: While ext_en_i is low, bus_abort_o is 1, and register writes and acknowledges have no effect on cfg_o.
- R8: When cfg bit 6 is set, driving ext_en_i low returns cfg_o to its power-on value and pulses regs_clear_o.
- R9: A bus write in the same cycle as an expiry stores its data in cfg_o, except that the run bit (bit 0) ends up set.
- R10: While ext_en_i is high, a write with cfg_we_i loads cfg_wdata_i into cfg_o on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_en_i | input | 1 | External bus-enable pin, active low, asynchronous |
| tick_i | input | 1 | One-cycle strobe per PWM clock period |
| ack_i | input | 1 | Strobe from the bus engine when it acknowledges this device's address |
| cfg_we_i | input | 1 | Configuration register write strobe from the bus engine |
| cfg_wdata_i | input | 8 | Configuration register write data |
| cfg_o | output | 8 | Configuration register contents |
| run_o | output | 1 | Run bit (cfg bit 0), high when the driver is out of shutdown |
| bus_abort_o | output | 1 | High while the pin holds the bus interface off |
| regs_clear_o | output | 1 | High while the pin-driven register clear is being applied |
| wake_o | output | 1 | One-cycle pulse when the timeout sets the run bit |
| window_active_o | output | 1 | High while a timeout window is open |

## Verification
The bench targets the two ends of the timeout window. If the count is off by one, the run bit appears after the 127th tick or only after the 129th. It also drives an acknowledge on the same strobe as the final tick; a design that lets expiry win there wakes the driver when it should not. An acknowledge placed between ticks checks that the pending flag is held until the next tick. Pin drops partway through a window check that a design which does not restart its counter wakes early on the next edge. Writes that coincide with expiry, and writes or acknowledges while the pin is low, check that the block's own bit updates take priority and that the bus is really shut out.

// File: rtl/reset_run_wake_pkg.sv
package reset_run_wake_pkg;
  localparam int RUN_BIT  = 0;
  localparam int ARM_BIT  = 1;
  localparam int WIPE_BIT = 6;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } win_state_e;
endpackage

// File: rtl/rrw_pin_sync.sv
module rrw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/rrw_window_timer.sv
module rrw_window_timer
  import reset_run_wake_pkg::*;
#(
  parameter int WINDOW = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic abort_i,
  input  logic ack_i,
  output logic expire_o,
  output logic cancel_o,
  output logic active_o
);
  localparam int CW = $clog2(WINDOW + 1);

  win_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          ack_pend_q;
  logic          ack_seen, step;

  assign ack_seen = ack_pend_q | ack_i;
  assign step     = (st_q == ST_WAIT) & tick_i & ~abort_i;
  // cancel has priority over expiry on the same tick
  assign cancel_o = step & ack_seen;
  assign expire_o = step & ~ack_seen & (cnt_q == CW'(WINDOW - 1));
  assign active_o = (st_q == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      ack_pend_q <= 1'b0;
    end else if (start_i) begin
      st_q       <= ST_WAIT;
      cnt_q      <= '0;
      ack_pend_q <= 1'b0;
    end else if (abort_i || cancel_o || expire_o) begin
      st_q       <= ST_IDLE;
      ack_pend_q <= 1'b0;
    end else if (step) begin
      cnt_q      <= cnt_q + 1'b1;
      ack_pend_q <= 1'b0;
    end else if (st_q == ST_WAIT) begin
      ack_pend_q <= ack_seen; // stretch until the next tick
    end
  end
endmodule

// File: rtl/rrw_cfg_reg.sv
module rrw_cfg_reg
  import reset_run_wake_pkg::*;
#(
  parameter int             W   = 8,
  parameter logic [W-1:0]   POR = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         set_run_i,
  input  logic         clr_arm_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= POR;
    end else if (clear_i) begin
      cfg_q <= POR;
    end else begin
      if (we_i)      cfg_q          <= wdata_i;
      // block updates override a bus write in the same cycle
      if (set_run_i) cfg_q[RUN_BIT] <= 1'b1;
      if (clr_arm_i) cfg_q[ARM_BIT] <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/reset_run_wake.sv
module reset_run_wake
  import reset_run_wake_pkg::*;
#(
  parameter int               CFG_W       = 8,
  parameter logic [CFG_W-1:0] CFG_POR     = '0,
  parameter int               WINDOW      = 128,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_en_i,
  input  logic             tick_i,
  input  logic             ack_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             run_o,
  output logic             bus_abort_o,
  output logic             regs_clear_o,
  output logic             wake_o,
  output logic             window_active_o
);
  logic             en_lvl, en_rise;
  logic             expire_w, cancel_w, active_w;
  logic             clr_w, start_w;
  logic [CFG_W-1:0] cfg_w;
  logic             wake_q;

  rrw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (ext_en_i),
    .level_o (en_lvl),
    .rise_o  (en_rise)
  );

  assign clr_w   = ~en_lvl & cfg_w[WIPE_BIT];
  assign start_w = en_rise & cfg_w[ARM_BIT];

  rrw_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .start_i  (start_w),
    .abort_i  (~en_lvl),
    .ack_i    (ack_i & en_lvl),
    .expire_o (expire_w),
    .cancel_o (cancel_w),
    .active_o (active_w)
  );

  rrw_cfg_reg #(.W(CFG_W), .POR(CFG_POR)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clr_w),
    .we_i      (cfg_we_i & en_lvl),
    .wdata_i   (cfg_wdata_i),
    .set_run_i (expire_w),
    .clr_arm_i (cancel_w),
    .cfg_o     (cfg_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= expire_w;
  end

  assign cfg_o           = cfg_w;
  assign run_o           = cfg_w[RUN_BIT];
  assign bus_abort_o     = ~en_lvl;
  assign regs_clear_o    = clr_w;
  assign wake_o          = wake_q;
  assign window_active_o = active_w;
endmodule

// File: rtl/rrw_chk.sv
module rrw_chk #(
  parameter int           W   = 8,
  parameter logic [W-1:0] POR = '0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         expire_i,
  input logic         cancel_i,
  input logic         en_lvl_i,
  input logic         clr_i,
  input logic         active_i,
  input logic [W-1:0] cfg_i,
  input logic         wake_i
);
  // R2
  expire_sets_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> (cfg_i[0] && wake_i && !active_i));

  // R5
  cancel_clears_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> (!cfg_i[1] && !active_i && !wake_i));

  // R4
  drop_closes_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_lvl_i && active_i) |=> !active_i);

  // R7
  bus_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_lvl_i && !clr_i) |=> $stable(cfg_i));

  // R8
  regs_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cfg_i == POR));
endmodule

bind reset_run_wake rrw_chk #(.W(CFG_W), .POR(CFG_POR)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .expire_i (expire_w),
  .cancel_i (cancel_w),
  .en_lvl_i (en_lvl),
  .clr_i    (clr_w),
  .active_i (active_w),
  .cfg_i    (cfg_w),
  .wake_i   (wake_q)
);

// File: tb/reset_run_wake_tb.sv
module reset_run_wake_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_en_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_o;
  logic       run_o, bus_abort_o, regs_clear_o, wake_o, window_active_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  reset_run_wake u_dut (
    .clk_i, .rst_ni, .ext_en_i, .tick_i, .ack_i, .cfg_we_i, .cfg_wdata_i,
    .cfg_o, .run_o, .bus_abort_o, .regs_clear_o, .wake_o, .window_active_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected arm/run bits after a trial: 0 expire, 1 cancel, 2 drop then expire
  function automatic logic [1:0] exp_bits(int mode);
    return (mode == 1) ? 2'b00 : 2'b11;
  endfunction

  task automatic tick();
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      idle(1 + int'($urandom_range(0, 2)));
    end
  endtask

  task automatic wr(logic [7:0] d);
    cfg_we_i = 1'b1;
    cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic ack_pulse();
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic pin(logic v);
    ext_en_i = v;
    idle(3);
  endtask

  task automatic arm_and_rise();
    wr(8'h02);
    pin(1'b0);
    pin(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 cfg", cfg_o, 8'h00);
    chk("R1 abort", bus_abort_o, 1);
    chk("R1 active", window_active_o, 0);
    chk("R1 wake", wake_o, 0);
    chk("R1 clear", regs_clear_o, 0);

    // R10 write while pin high
    pin(1'b1);
    wr(8'h3C);
    chk("R10 write", cfg_o, 8'h3C);

    // R7 bus shut out while pin low
    pin(1'b0);
    chk("R7 abort", bus_abort_o, 1);
    wr(8'hFF);
    ack_pulse();
    chk("R7 ignored", cfg_o, 8'h3C);

    // R3 no arm -> no window
    pin(1'b1);
    chk("R3 active", window_active_o, 0);
    ticks(130);
    chk("R3 run", run_o, 0);

    // R2 expiry boundary
    arm_and_rise();
    chk("R2 active", window_active_o, 1);
    ticks(127);
    chk("R2 run at 127", run_o, 0);
    tick();
    chk("R2 run at 128", cfg_o[1:0], 2'b11);
    chk("R2 wake", wake_o, 1);
    chk("R2 closed", window_active_o, 0);
    idle(1);
    chk("R2 wake pulse", wake_o, 0);

    // R4 drop restarts full count
    arm_and_rise();
    ticks(60);
    pin(1'b0);
    chk("R4 closed", window_active_o, 0);
    chk("R4 cfg kept", cfg_o[1:0], 2'b10);
    pin(1'b1);
    ticks(127);
    chk("R4 run at 127", run_o, 0);
    tick();
    chk("R4 run at 128", run_o, 1);

    // R5 ack between ticks cancels at next tick
    arm_and_rise();
    ticks(50);
    ack_pulse();
    chk("R5 still open", window_active_o, 1);
    tick();
    chk("R5 cancel", cfg_o[1:0], 2'b00);
    chk("R5 closed", window_active_o, 0);
    ticks(100);
    chk("R5 no wake", run_o, 0);

    // R6 ack on the final tick
    arm_and_rise();
    ticks(127);
    ack_i = 1'b1;
    tick();
    ack_i = 1'b0;
    chk("R6 cancel wins", cfg_o[1:0], 2'b00);
    chk("R6 wake", wake_o, 0);

    // R9 write coinciding with expiry
    arm_and_rise();
    ticks(127);
    cfg_we_i = 1'b1;
    cfg_wdata_i = 8'h30;
    tick();
    cfg_we_i = 1'b0;
    chk("R9 merge", cfg_o, 8'h31);

    // R8 pin-driven register wipe
    wr(8'h42);
    ext_en_i = 1'b0;
    idle(2);
    chk("R8 clear pulse", regs_clear_o, 1);
    idle(1);
    chk("R8 wiped", cfg_o, 8'h00);
    chk("R8 pulse end", regs_clear_o, 0);
    pin(1'b1);

    // random trials
    for (int t = 0; t < 20; t++) begin
      int mode = int'($urandom_range(0, 2));
      int k = int'($urandom_range(0, 127));
      arm_and_rise();
      if (mode == 2) begin
        ticks(k);
        pin(1'b0);
        pin(1'b1);
      end
      for (int i = 0; i < 128; i++) begin
        if (mode == 1 && i == k) ack_pulse();
        tick();
        idle(1);
      end
      if (mode == 1) chk("R5 random cancel", cfg_o[1:0], exp_bits(mode));
      else           chk("R2 random expire", cfg_o[1:0], exp_bits(mode));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule